// File: doc/BRIEF.md
# Track Format Byte Translator

This block sits between the host data register and the bit encoder during a whole-track format pass. Each time the encoder asks for a byte with a one-cycle slot strobe, the block hands it the next byte. Most host bytes go through as they are. Three control values change the stream instead. One writes an A1 mark with a clock bit left out and arms the checksum. One writes a C2 mark with a clock bit left out. One inserts the two bytes of the running checksum, so it takes two slots.

A format pass starts with a one-cycle `start` pulse. The data request goes up at once, so the host can preload the first byte. Output begins at the first rising edge of `index` and ends at the next one, which raises `done`. If the host has loaded nothing by the first index edge, the pass aborts with `lost` set. If the host falls behind while writing, a zero byte is sent in its place, `lost` is set and writing goes on.

Top module: `fmt_track_xlat`

## Requirements
- R1: After reset, `busy`, `drq`, `done`, `lost` and `out_valid` are all 0.
- R2: A `start` pulse while not busy sets `busy` and `drq` to 1 on the next cycle, clears `done` and `lost`, and empties the holding register.
- R3: A `host_load` pulse while busy stores `host_byte` and drives `drq` to 0 on the next cycle.
- R4: A held byte in 0x00..0xF4 or 0xF8..0xFF is sent unchanged on the next slot with `out_mc`=0. `drq` then returns to 1.
- R5: A held 0xF5 is sent as 0xA1 with `out_mc`=1. If the byte sent before it was not an A1 mark, the checksum is first preset to 0xFFFF. The A1 is always folded into the checksum, so three 0xF5 in a row leave the checksum at 0xCDB4.
- R6: A held 0xF6 is sent as 0xC2 with `out_mc`=1 and is folded into the checksum.
- R7: A held 0xF7 uses two slots. It sends the checksum high byte, then the low byte, both with `out_mc`=0. The checksum is CRC-16 with polynomial 0x1021, fed MSB first. The two checksum bytes are not folded into it. `drq` stays 0 until the low byte has gone out, and stays 0 after that if the host has loaded again meanwhile.
- R8: Slots that come before the first rising edge of `index` produce no output.
- R9: If the holding register is empty at the first rising edge of `index`, the next cycle shows `busy`=0, `lost`=1, `done`=1 and `drq`=0.
- R10: A slot that finds the holding register empty while writing sends 0x00 with `out_mc`=0 and folds it into the checksum. It sets `lost`, and `busy` and `drq` stay 1.
- R11: The second rising edge of `index` ends the pass. The next cycle shows `busy`=0, `done`=1 and `drq`=0, and later slots produce no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a format pass |
| host_byte | input | 8 | Byte written by the host |
| host_load | input | 1 | One-cycle pulse: the host writes `host_byte` |
| index | input | 1 | Index sensor level; rising edges frame the pass |
| slot | input | 1 | One-cycle strobe: the encoder needs a byte |
| out_byte | output | 8 | Byte sent to the encoder |
| out_mc | output | 1 | `out_byte` is a mark written with a missing clock |
| out_valid | output | 1 | One-cycle pulse: `out_byte` is new |
| drq | output | 1 | Holding register wants a byte |
| lost | output | 1 | An underrun or an abort happened in this pass |
| done | output | 1 | The pass has finished; cleared by the next start |
| busy | output | 1 | A pass is in progress |

## Verification
A stale preset or a missed fold corrupts the checksum, but nothing shows until the next 0xF7. The two emitted bytes then differ from the value the bench works out from everything sent since the last A1 run. A wrong two-slot state shows in the very next slot: a byte is dropped or repeated, or `drq` rises one slot early. A framing fault shows one cycle after an index edge as wrong `busy`, `done` or `lost`, or later as output that should not appear.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

    localparam int BYTE_W = 8;
    localparam int CRC_W  = 16;

    localparam logic [BYTE_W-1:0] CODE_MARK = 8'hF5;
    localparam logic [BYTE_W-1:0] CODE_SYNC = 8'hF6;
    localparam logic [BYTE_W-1:0] CODE_SUM  = 8'hF7;
    localparam logic [BYTE_W-1:0] MARK_A1   = 8'hA1;
    localparam logic [BYTE_W-1:0] MARK_C2   = 8'hC2;

    typedef enum logic [1:0] {PH_IDLE, PH_ARM, PH_WRITE} phase_t;
    typedef enum logic [1:0] {K_PLAIN, K_MARK_A1, K_MARK_C2, K_SUM} kind_t;

    typedef struct packed {
        logic [BYTE_W-1:0] val;
        logic              mc;
        kind_t             kind;
    } xlat_t;

    function automatic xlat_t xlate(input logic [BYTE_W-1:0] b);
        xlat_t r;
        r.val  = b;
        r.mc   = 1'b0;
        r.kind = K_PLAIN;
        if (b == CODE_MARK) begin
            r.val = MARK_A1; r.mc = 1'b1; r.kind = K_MARK_A1;
        end else if (b == CODE_SYNC) begin
            r.val = MARK_C2; r.mc = 1'b1; r.kind = K_MARK_C2;
        end else if (b == CODE_SUM) begin
            r.kind = K_SUM;
        end
        return r;
    endfunction

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic [BYTE_W-1:0] d,
                                                  input logic [CRC_W-1:0] poly);
        logic [CRC_W-1:0] n;
        logic fb;
        n = c;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            fb = n[CRC_W-1] ^ d[i];
            n  = {n[CRC_W-2:0], 1'b0};
            if (fb) n = n ^ poly;
        end
        return n;
    endfunction

endpackage

// File: rtl/fmt_edge_det.sv
module fmt_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/fmt_crc_acc.sv
module fmt_crc_acc
    import fmt_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = 16'h1021,
    parameter logic [CRC_W-1:0] INIT = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              preset,
    input  logic [BYTE_W-1:0] din,
    output logic [CRC_W-1:0]  crc
);
    always_ff @(posedge clk) begin
        if (rst)
            crc <= INIT;
        else if (en)
            crc <= crc_step(preset ? INIT : crc, din, POLY);
    end

    // The sum only moves on a folded byte
    AST_SUM_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(crc)); // R7
endmodule

// File: rtl/fmt_hold_reg.sv
module fmt_hold_reg
    import fmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              load,
    input  logic [BYTE_W-1:0] din,
    input  logic              take,
    output logic [BYTE_W-1:0] q,
    output logic              full
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            full <= 1'b0;
        end else if (load) begin
            q    <= din;
            full <= 1'b1;
        end else if (clr || take) begin
            full <= 1'b0;
        end
    end

    AST_LOAD_FILLS: assert property (@(posedge clk) disable iff (rst)
        load |=> full && q == $past(din)); // R3
endmodule

// File: rtl/fmt_track_xlat.sv
module fmt_track_xlat
    import fmt_pkg::*;
#(
    parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021,
    parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BYTE_W-1:0] host_byte,
    input  logic              host_load,
    input  logic              index,
    input  logic              slot,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_mc,
    output logic              out_valid,
    output logic              drq,
    output logic              lost,
    output logic              done,
    output logic              busy
);
    phase_t            phase;
    logic              idx_rise;
    logic [BYTE_W-1:0] dr_q;
    logic              dr_full;
    logic [CRC_W-1:0]  crc;
    logic              sum_lo_pend;
    logic              last_a1;
    xlat_t             xl;
    logic              wslot, take, fold, preset, begin_pass;
    logic [BYTE_W-1:0] fold_byte;

    fmt_edge_det u_edge (.clk(clk), .rst(rst), .lvl(index), .rise(idx_rise));

    always_comb begin
        xl         = xlate(dr_q);
        begin_pass = (phase == PH_IDLE) && start;
        wslot      = (phase == PH_WRITE) && !idx_rise && slot && !sum_lo_pend;
        take       = wslot && dr_full;
        fold       = wslot && !(dr_full && xl.kind == K_SUM);
        fold_byte  = dr_full ? xl.val : '0;
        preset     = dr_full && xl.kind == K_MARK_A1 && !last_a1;
    end

    fmt_hold_reg u_hold (
        .clk(clk), .rst(rst), .clr(begin_pass), .load(host_load && busy),
        .din(host_byte), .take(take), .q(dr_q), .full(dr_full)
    );

    fmt_crc_acc #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
        .clk(clk), .rst(rst), .en(fold), .preset(preset),
        .din(fold_byte), .crc(crc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= PH_IDLE;
            busy        <= 1'b0;
            drq         <= 1'b0;
            lost        <= 1'b0;
            done        <= 1'b0;
            out_valid   <= 1'b0;
            out_byte    <= '0;
            out_mc      <= 1'b0;
            sum_lo_pend <= 1'b0;
            last_a1     <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            case (phase)
                PH_IDLE: if (start) begin
                    phase       <= PH_ARM;
                    busy        <= 1'b1;
                    drq         <= 1'b1;
                    lost        <= 1'b0;
                    done        <= 1'b0;
                    sum_lo_pend <= 1'b0;
                    last_a1     <= 1'b0;
                end
                PH_ARM: if (idx_rise) begin
                    if (dr_full) begin
                        phase <= PH_WRITE;
                    end else begin
                        phase <= PH_IDLE;
                        busy  <= 1'b0;
                        drq   <= 1'b0;
                        lost  <= 1'b1;
                        done  <= 1'b1;
                    end
                end
                PH_WRITE: begin
                    if (idx_rise) begin
                        phase <= PH_IDLE;
                        busy  <= 1'b0;
                        drq   <= 1'b0;
                        done  <= 1'b1;
                    end else if (slot) begin
                        out_valid <= 1'b1;
                        if (sum_lo_pend) begin
                            out_byte    <= crc[BYTE_W-1:0];
                            out_mc      <= 1'b0;
                            sum_lo_pend <= 1'b0;
                            drq         <= !dr_full;
                        end else if (dr_full) begin
                            if (xl.kind == K_SUM) begin
                                out_byte    <= crc[CRC_W-1:BYTE_W];
                                out_mc      <= 1'b0;
                                sum_lo_pend <= 1'b1;
                                last_a1     <= 1'b0;
                            end else begin
                                out_byte <= xl.val;
                                out_mc   <= xl.mc;
                                drq      <= 1'b1;
                                last_a1  <= (xl.kind == K_MARK_A1);
                            end
                        end else begin
                            out_byte <= '0;
                            out_mc   <= 1'b0;
                            lost     <= 1'b1;
                            last_a1  <= 1'b0;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
            if (host_load && busy && !(phase == PH_WRITE && idx_rise))
                drq <= 1'b0;
        end
    end

    AST_DRQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        drq |-> busy); // R2
    AST_MC_ONLY_MARKS: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_mc |-> out_byte == MARK_A1 || out_byte == MARK_C2); // R5
    AST_SYNC_MARK: assert property (@(posedge clk) disable iff (rst)
        take && dr_q == CODE_SYNC |=> out_valid && out_byte == MARK_C2 && out_mc); // R6
    AST_SUM_NO_DRQ: assert property (@(posedge clk) disable iff (rst)
        sum_lo_pend |-> !drq); // R7
    AST_OUT_ONLY_WRITING: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(phase == PH_WRITE)); // R8
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R11
endmodule

// File: tb/sim_fmt_track_xlat.sv
module sim_fmt_track_xlat;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] host_byte = 8'h00;
    logic       host_load = 1'b0;
    logic       index = 1'b0;
    logic       slot = 1'b0;
    logic [7:0] out_byte;
    logic       out_mc, out_valid, drq, lost, done, busy;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [15:0] m_crc = 16'hFFFF;
    bit          m_a1 = 1'b0;

    always #2 clk = ~clk;

    fmt_track_xlat u0 (
        .clk(clk), .rst(rst), .start(start), .host_byte(host_byte),
        .host_load(host_load), .index(index), .slot(slot),
        .out_byte(out_byte), .out_mc(out_mc), .out_valid(out_valid),
        .drq(drq), .lost(lost), .done(done), .busy(busy)
    );

    function automatic logic [15:0] m_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] n = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb = n[15] ^ d[i];
            n = {n[14:0], 1'b0};
            if (fb) n = n ^ 16'h1021;
        end
        return n;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic load(input logic [7:0] b);
        @(negedge clk); host_byte = b; host_load = 1'b1;
        @(negedge clk); host_load = 1'b0;
    endtask

    task automatic do_slot();
        @(negedge clk); slot = 1'b1;
        @(negedge clk); slot = 1'b0;
    endtask

    task automatic index_edge();
        @(negedge clk); index = 1'b1;
        @(negedge clk);
    endtask

    task automatic index_drop();
        index = 1'b0;
        @(negedge clk);
    endtask

    // Send one host byte and compare against the model
    task automatic send(input logic [7:0] v, input string tag);
        load(v);
        chk({tag, " R3 drq after load"}, drq, 0);
        do_slot();
        if (v == 8'hF7) begin
            chk({tag, " R7 sum hi"}, {out_valid, out_mc, out_byte}, {1'b1, 1'b0, m_crc[15:8]});
            chk({tag, " R7 drq held"}, drq, 0);
            do_slot();
            chk({tag, " R7 sum lo"}, {out_valid, out_mc, out_byte}, {1'b1, 1'b0, m_crc[7:0]});
            chk({tag, " R7 drq back"}, drq, 1);
            m_a1 = 1'b0;
        end else if (v == 8'hF5) begin
            chk({tag, " R5 A1 mark"}, {out_valid, out_mc, out_byte}, {2'b11, 8'hA1});
            m_crc = m_step(m_a1 ? m_crc : 16'hFFFF, 8'hA1);
            m_a1  = 1'b1;
        end else if (v == 8'hF6) begin
            chk({tag, " R6 C2 mark"}, {out_valid, out_mc, out_byte}, {2'b11, 8'hC2});
            m_crc = m_step(m_crc, 8'hC2);
            m_a1  = 1'b0;
        end else begin
            chk({tag, " R4 literal"}, {out_valid, out_mc, out_byte}, {2'b10, v});
            chk({tag, " R4 drq back"}, drq, 1);
            m_crc = m_step(m_crc, v);
            m_a1  = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset outputs", {busy, drq, done, lost, out_valid}, 5'b0);

        pulse_start();
        chk("R2 busy and drq", {busy, drq, done, lost}, 4'b1100);
        do_slot();
        chk("R8 no output before index", out_valid, 0);
        index_edge();
        chk("R9 abort", {busy, lost, done, drq}, 4'b0110);
        index_drop();

        pulse_start();
        chk("R2 flags cleared", {busy, drq, done, lost}, 4'b1100);
        load(8'h4E);
        chk("R3 drq after preload", drq, 0);
        do_slot();
        chk("R8 slot ignored while armed", out_valid, 0);
        index_edge();
        chk("R9 no abort when loaded", {busy, lost, done}, 3'b100);
        index_drop();
        do_slot();
        chk("R4 first byte", {out_valid, out_mc, out_byte}, {2'b10, 8'h4E});
        m_crc = m_step(16'hFFFF, 8'h4E);
        m_a1  = 1'b0;

        for (int v = 0; v < 256; v++) send(v[7:0], "sweep");

        do_slot();
        chk("R10 zero byte", {out_valid, out_mc, out_byte}, {2'b10, 8'h00});
        chk("R10 flags", {lost, busy, drq}, 3'b111);
        m_crc = m_step(m_crc, 8'h00);
        m_a1  = 1'b0;

        send(8'hF5, "run");
        send(8'hF5, "run");
        send(8'hF5, "run");
        chk("R5 three marks", m_crc, 16'hCDB4);
        send(8'hF7, "run");
        send(8'hF5, "id");
        send(8'hF5, "id");
        send(8'hF5, "id");
        send(8'hFE, "id");
        send(8'h07, "id");
        send(8'h00, "id");

        load(8'hF7);
        do_slot();
        chk("R7 hi before reload", {out_valid, out_byte}, {1'b1, m_crc[15:8]});
        load(8'h11);
        do_slot();
        chk("R7 lo with reload", {out_valid, out_byte}, {1'b1, m_crc[7:0]});
        chk("R7 drq stays low when refilled", drq, 0);
        do_slot();
        chk("R4 byte after sum", {out_valid, out_mc, out_byte}, {2'b10, 8'h11});

        index_edge();
        chk("R11 end of pass", {busy, done, drq}, 3'b010);
        index_drop();
        do_slot();
        chk("R11 no output after end", out_valid, 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule